// File: doc/BRIEF.md
# Debug Host Datagram Bridge

This bridge sits between a host transport and an on-chip debug interconnect. Host traffic arrives as 16-bit datagrams: one length word followed by that many payload words. The interconnect carries packets whose end is marked by a last flag instead of a count. On the way in, the bridge consumes the length word and passes the payload straight through as one packet, raising last on its final word. The leading payload words, which hold the routing and type information of the debug packet, are forwarded untouched.

On the way out, the bridge cannot know a packet's length until the last flag appears. It therefore stores the whole packet in a buffer of `MAX_PKT` words. When the packet is complete it emits the word count as a header, followed by the stored words in order. A packet that does not fit is discarded as a whole, and a one-cycle drop pulse marks the event. The two directions run independently. A host-driven reset request is passed on as the system reset, and it also returns both directions to their idle state.

Top module: `dbg_host_bridge`

## Requirements
- R1: After a host length word N > 0 has been accepted, the next N host words are forwarded unchanged to the interconnect output, and the length word itself is never forwarded.
- R2: `pout_last` is high on the N-th forwarded word of a datagram and low on every other forwarded word.
- R3: A host length word of 0 is accepted and discarded, and no word appears on the interconnect output.
- R4: After an interconnect packet of L words (1 ≤ L ≤ MAX_PKT) has ended with `pin_last`, the host output carries the word L, zero-extended, and then the L words in arrival order. `pin_ready` stays low from the final word until the last of these has been sent.
- R5: A packet of exactly MAX_PKT words is delivered in full.
- R6: A packet longer than MAX_PKT words produces nothing on the host output. `drop_pulse` is high for exactly one cycle, the cycle after its last word was accepted.
- R7: A word moves on a port only in a cycle where that port's valid and ready are both high. While `hout_valid` is high and `hout_ready` is low, `hout_data` holds its value.
- R8: Ingress and egress traffic can flow in the same cycles without affecting each other's contents.
- R9: `sys_rst` follows `host_rst`. While `host_rst` is high, a partly received datagram and a partly buffered or partly sent packet are abandoned, and the next traffic is handled from the idle state.
- R10: After `rst_n` is released, `hin_ready` and `pin_ready` are high, and `pout_valid`, `hout_valid` and `drop_pulse` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low local reset |
| host_rst | input | 1 | Reset request from the host transport |
| sys_rst | output | 1 | System reset passed on from `host_rst` |
| hin_data | input | W | Host-to-chip word (length word or payload) |
| hin_valid | input | 1 | Host-to-chip word valid |
| hin_ready | output | 1 | Bridge accepts a host word |
| pout_data | output | W | Interconnect packet word out |
| pout_valid | output | 1 | Interconnect word out valid |
| pout_last | output | 1 | Final word of the outgoing packet |
| pout_ready | input | 1 | Interconnect accepts a word |
| pin_data | input | W | Interconnect packet word in |
| pin_valid | input | 1 | Interconnect word in valid |
| pin_last | input | 1 | Final word of the incoming packet |
| pin_ready | output | 1 | Bridge accepts an interconnect word |
| hout_data | output | W | Chip-to-host word (length word or payload) |
| hout_valid | output | 1 | Chip-to-host word valid |
| hout_ready | input | 1 | Host accepts a word |
| drop_pulse | output | 1 | One-cycle pulse for an oversize packet that was discarded |

## Verification
Two events can fall in the same cycle: the final word of a host datagram leaving with `pout_last`, and egress activity such as a header being sent or an oversize packet being dropped. The bench starts both streams together in parallel threads, while ready patterns of different periods stall each side. It judges each direction by capturing the full word sequence and the last flags, and comparing them against values computed from the lengths and data patterns. One run places an oversize egress packet alongside an ingress datagram so that the drop pulse and the ingress traffic overlap.

// File: rtl/dbg_host_bridge.sv
module dbg_host_bridge #(
  parameter int W       = 16,
  parameter int MAX_PKT = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         host_rst,
  output logic         sys_rst,
  input  logic [W-1:0] hin_data,
  input  logic         hin_valid,
  output logic         hin_ready,
  output logic [W-1:0] pout_data,
  output logic         pout_valid,
  output logic         pout_last,
  input  logic         pout_ready,
  input  logic [W-1:0] pin_data,
  input  logic         pin_valid,
  input  logic         pin_last,
  output logic         pin_ready,
  output logic [W-1:0] hout_data,
  output logic         hout_valid,
  input  logic         hout_ready,
  output logic         drop_pulse
);
  localparam int CW = $clog2(MAX_PKT + 1);
  localparam int AW = $clog2(MAX_PKT);

  assign sys_rst = host_rst;

  // host -> interconnect
  logic         in_body;
  logic [W-1:0] in_left;

  assign hin_ready  = in_body ? pout_ready : 1'b1;
  assign pout_valid = in_body & hin_valid;
  assign pout_data  = hin_data;
  assign pout_last  = in_body && (in_left == W'(1));

  wire in_fire = hin_valid & hin_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_body <= 1'b0;
      in_left <= '0;
    end else if (host_rst) begin
      in_body <= 1'b0;
      in_left <= '0;
    end else if (in_fire) begin
      if (!in_body) begin
        in_left <= hin_data;
        in_body <= (hin_data != '0);
      end else begin
        in_left <= in_left - W'(1);
        if (in_left == W'(1)) in_body <= 1'b0;
      end
    end
  end

  // interconnect -> host
  typedef enum logic [1:0] {E_COLLECT, E_HDR, E_SEND} estate_t;

  estate_t       est;
  logic [CW-1:0] ecnt;
  logic [CW-1:0] erd;
  logic [W-1:0]  mem_q [MAX_PKT];

  wire full      = (ecnt == CW'(MAX_PKT));
  wire pin_fire  = pin_valid & pin_ready;
  wire hout_fire = hout_valid & hout_ready;

  assign pin_ready  = (est == E_COLLECT);
  assign hout_valid = (est != E_COLLECT);
  assign hout_data  = (est == E_HDR) ? W'(ecnt) : mem_q[erd[AW-1:0]];

  always_ff @(posedge clk) begin
    if (pin_fire && !full) mem_q[ecnt[AW-1:0]] <= pin_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      est        <= E_COLLECT;
      ecnt       <= '0;
      erd        <= '0;
      drop_pulse <= 1'b0;
    end else if (host_rst) begin
      est        <= E_COLLECT;
      ecnt       <= '0;
      erd        <= '0;
      drop_pulse <= 1'b0;
    end else begin
      drop_pulse <= 1'b0;
      case (est)
        E_COLLECT: if (pin_fire) begin
          if (!full) ecnt <= ecnt + CW'(1);
          if (pin_last) begin
            if (full) begin
              drop_pulse <= 1'b1;
              ecnt       <= '0;
            end else begin
              est <= E_HDR;
            end
          end
        end
        E_HDR: if (hout_fire) begin
          est <= E_SEND;
          erd <= '0;
        end
        default: if (hout_fire) begin
          if (erd == ecnt - CW'(1)) begin
            est  <= E_COLLECT;
            ecnt <= '0;
            erd  <= '0;
          end else begin
            erd <= erd + CW'(1);
          end
        end
      endcase
    end
  end
endmodule

module dbg_host_bridge_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         host_rst,
  input logic [W-1:0] hin_data,
  input logic         hin_valid,
  input logic         hin_ready,
  input logic         pout_valid,
  input logic         pout_last,
  input logic         pout_ready,
  input logic         pin_valid,
  input logic         pin_last,
  input logic         pin_ready,
  input logic [W-1:0] hout_data,
  input logic         hout_valid,
  input logic         hout_ready,
  input logic         drop_pulse
);
  p_zero_len_r3: assert property (@(posedge clk) disable iff (!rst_n || host_rst)
    (hin_valid && hin_ready && !pout_valid && hin_data == '0) |=> !pout_valid);

  p_last_ends_r2: assert property (@(posedge clk) disable iff (!rst_n || host_rst)
    (pout_valid && pout_ready && pout_last) |=> !pout_valid);

  p_hold_hout_r7: assert property (@(posedge clk) disable iff (!rst_n || host_rst)
    (hout_valid && !hout_ready) |=> (hout_valid && $stable(hout_data)));

  p_drop_single_r6: assert property (@(posedge clk) disable iff (!rst_n || host_rst)
    drop_pulse |=> !drop_pulse);

  p_drop_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n || host_rst)
    $rose(drop_pulse) |-> $past(pin_valid && pin_ready && pin_last));

  p_host_reset_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    host_rst |=> (!hout_valid && !pout_valid && !drop_pulse));
endmodule

bind dbg_host_bridge dbg_host_bridge_chk #(.W(W)) i_chk (.*);

// File: tb/test_dbg_host_bridge.sv
module test_dbg_host_bridge;
  localparam int W = 16;
  localparam int MAXP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_rst = 1'b0;
  logic sys_rst;
  logic [W-1:0] hin_data = '0;
  logic hin_valid = 1'b0;
  logic hin_ready;
  logic [W-1:0] pout_data;
  logic pout_valid, pout_last;
  logic pout_ready = 1'b1;
  logic [W-1:0] pin_data = '0;
  logic pin_valid = 1'b0;
  logic pin_last = 1'b0;
  logic pin_ready;
  logic [W-1:0] hout_data;
  logic hout_valid;
  logic hout_ready = 1'b1;
  logic drop_pulse;

  always #2 clk = ~clk;

  dbg_host_bridge #(.W(W), .MAX_PKT(MAXP)) i_dbg_host_bridge (.*);

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [W-1:0] p_word [0:63];
  logic         p_last [0:63];
  int np = 0;
  logic [W-1:0] h_word [0:63];
  int nh = 0;
  int ndrop = 0;

  always @(negedge clk) begin
    cyc++;
    pout_ready = (cyc % 3) != 2;
    hout_ready = (cyc % 5) != 3;
  end

  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (pout_valid && pout_ready && np < 64) begin
        p_word[np] = pout_data; p_last[np] = pout_last; np++;
      end
      if (hout_valid && hout_ready && nh < 64) begin
        h_word[nh] = hout_data; nh++;
      end
      if (drop_pulse) ndrop++;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic hin_put(input logic [W-1:0] w);
    hin_data = w; hin_valid = 1'b1; #1;
    while (!hin_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    hin_valid = 1'b0;
  endtask

  task automatic pin_put(input logic [W-1:0] w, input logic l);
    pin_data = w; pin_last = l; pin_valid = 1'b1; #1;
    while (!pin_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    pin_valid = 1'b0; pin_last = 1'b0;
  endtask

  function automatic logic [W-1:0] ipat(input int l, input int i);
    return W'(16'h1A00 + l * 16 + i);
  endfunction

  function automatic logic [W-1:0] epat(input int l, input int i);
    return W'(16'h4C00 + l * 16 + i);
  endfunction

  task automatic send_dgram(input int l);
    hin_put(W'(l));
    for (int i = 0; i < l; i++) hin_put(ipat(l, i));
  endtask

  task automatic send_pkt(input int l);
    for (int i = 0; i < l; i++) pin_put(epat(l, i), i == l - 1);
  endtask

  task automatic judge_ingress(input int l);
    int bad_d, bad_l;
    bad_d = 0; bad_l = 0;
    chk(l == 0 ? "R3 zero length word count" : "R1 word count", np, l);
    for (int i = 0; i < np; i++) begin
      if (p_word[i] != ipat(l, i)) bad_d++;
      if (p_last[i] != (i == l - 1)) bad_l++;
    end
    chk("R1 payload words", bad_d, 0);
    chk("R2 last flag placement", bad_l, 0);
  endtask

  task automatic judge_egress(input int l);
    if (l <= MAXP) begin
      int bad;
      bad = 0;
      chk(l == MAXP ? "R5 full packet word count" : "R4 word count", nh, l + 1);
      if (nh > 0) chk("R4 header value", int'(h_word[0]), l);
      for (int i = 1; i < nh; i++) if (h_word[i] != epat(l, i - 1)) bad++;
      chk("R4 payload order", bad, 0);
      chk("R6 no drop pulse", ndrop, 0);
    end else begin
      chk("R6 oversize nothing sent", nh, 0);
      chk("R6 drop pulse cycles", ndrop, 1);
    end
  endtask

  task automatic clear_mon;
    np = 0; nh = 0; ndrop = 0;
  endtask

  task automatic pulse_host_rst;
    @(negedge clk);
    host_rst = 1'b1; #1;
    chk("R9 sys_rst high", int'(sys_rst), 1);
    @(negedge clk);
    host_rst = 1'b0; #1;
    chk("R9 sys_rst low", int'(sys_rst), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R10 hin_ready", int'(hin_ready), 1);
    chk("R10 pin_ready", int'(pin_ready), 1);
    chk("R10 pout_valid", int'(pout_valid), 0);
    chk("R10 hout_valid", int'(hout_valid), 0);
    chk("R10 drop_pulse", int'(drop_pulse), 0);
    @(negedge clk);

    for (int l = 0; l <= 6; l++) begin
      clear_mon();
      send_dgram(l);
      repeat (12) @(negedge clk);
      judge_ingress(l);
    end

    for (int l = 1; l <= MAXP + 2; l++) begin
      clear_mon();
      send_pkt(l);
      repeat (30) @(negedge clk);
      judge_egress(l);
    end

    // R8: both directions at once, then an oversize drop alongside ingress
    clear_mon();
    fork
      send_dgram(3);
      send_pkt(3);
    join
    repeat (30) @(negedge clk);
    judge_ingress(3);
    judge_egress(3);

    clear_mon();
    fork
      send_dgram(4);
      send_pkt(MAXP + 2);
    join
    repeat (30) @(negedge clk);
    judge_ingress(4);
    judge_egress(MAXP + 2);

    // R9: abandon a partial egress packet
    clear_mon();
    pin_put(16'hDEAD, 1'b0);
    pin_put(16'hBEEF, 1'b0);
    pulse_host_rst();
    send_pkt(2);
    repeat (30) @(negedge clk);
    chk("R9 egress after reset count", nh, 3);
    if (nh > 0) chk("R9 egress after reset header", int'(h_word[0]), 2);

    // R9: abandon a partial ingress datagram
    hin_put(W'(5));
    hin_put(16'h0101);
    hin_put(16'h0202);
    pulse_host_rst();
    clear_mon();
    hin_put(W'(1));
    hin_put(16'h7E57);
    repeat (12) @(negedge clk);
    chk("R9 ingress after reset count", np, 1);
    if (np > 0) begin
      chk("R9 ingress after reset data", int'(p_word[0]), 16'h7E57);
      chk("R9 ingress after reset last", int'(p_last[0]), 1);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule